// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Unit

This block gathers a set of interrupt request lines, decides which one the processor should service next, and delivers a vector address to the core. Each line is configured at elaboration time as one of two kinds. An event line records a one-cycle pulse in a sticky pending flag. A level line has no flag and requests only while its input is high. A per-line enable mask and a global enable gate every request. The lowest-numbered pending and enabled line always wins.

The core is represented by strobes. One marks an instruction boundary, one marks a sleeping core, and others set or clear the global enable, start a return from a handler, and acknowledge a vector.

Once a request is accepted, the unit clears the global enable and clears the serviced flag. It then waits a fixed response time, which is longer when the core was asleep, and raises a take request. That request stays high until the core acknowledges it.

A return sequence restores the global enable after a fixed number of cycles. After the global enable is set by either path, one whole instruction must run before another request can be accepted. Vector slot 0 is reserved for reset, so request line `i` maps to slot `i+1`. The vector table sits either at address zero or at a relocatable boot base.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `take_req` is 0, `gie` is 0, and every bit of `flag_q` is 0.
- R2: A pulse on an event line sets its bit in `flag_q` whatever the enables are. The bit then stays set, and no request is taken while that line's `src_en` bit or `gie` is 0.
- R3: Driving a 1 on bit `i` of `flag_w1c` clears flag `i` on the next clock edge and leaves every other flag as it was.
- R4: A level line (bits 6 and 7 with the default mask) never sets a flag. If its input falls before it is enabled, no request is ever taken for it.
- R5: When several enabled lines are pending, the line with the lowest index is the one serviced.
- R6: On acceptance, `gie` goes to 0 and the serviced line's event flag is cleared. Flags of other lines are untouched.
- R7: `take_req` rises exactly 5 clock edges after the acceptance edge, or 10 edges if `core_sleep` was high at acceptance. It then stays high until `take_ack` is seen.
- R8: `vec_addr` equals base + 2*(i+1) for serviced line `i`. The base is 0 when `boot_vec_sel` is 0 and 0x3800 when it is 1.
- R9: A `ret_strobe` taken while idle sets `gie` exactly 5 clock edges later.
- R10: After `gie` is set by `gie_set` or by a completed return, the first `insn_bound` does not accept a request. The next boundary does.
- R11: A `gie_clr` in the same cycle as an otherwise valid acceptance blocks it, and `gie` reads 0 afterwards.
- R12: A request is accepted only in a cycle with `insn_bound` or `core_sleep` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Request lines: pulses for event lines, levels for level lines |
| src_en | input | NUM_SRC | Per-line enable mask |
| flag_w1c | input | NUM_SRC | Write-one-to-clear strobe for pending flags |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable, effective at once |
| ret_strobe | input | 1 | Start of return from handler |
| insn_bound | input | 1 | Core is at an instruction boundary this cycle |
| core_sleep | input | 1 | Core is asleep |
| boot_vec_sel | input | 1 | Place vector table at the boot base |
| take_ack | input | 1 | Core has taken the vector |
| take_req | output | 1 | Vector ready for the core |
| vec_addr | output | ADDR_W | Vector word address |
| gie | output | 1 | Global enable state |
| flag_q | output | NUM_SRC | Pending event flags |

## Verification
The bench goes after the shadow instruction. A unit that ignores it would vector on the first boundary after an enable or a return, and would reach `take_req` one instruction early.

It also pulses `gie_clr` in the very cycle an acceptance would happen. A design that gives acceptance priority would still raise `take_req`.

A level line is dropped before it is enabled, to catch a design that latches level lines and later services a phantom request. Masked event lines must keep their flags and lose the priority race only while masked. The latency is measured both awake and asleep, so that a missing or doubled wake-up penalty shows up as a wrong cycle count.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
   typedef enum logic [1:0] {
      IVU_IDLE = 2'd0,
      IVU_RESP = 2'd1,
      IVU_TAKE = 2'd2,
      IVU_RET  = 2'd3
   } ivu_state_e;
endpackage

// File: rtl/ivu_flag_bank.sv
module ivu_flag_bank #(
   parameter int                   NUM_SRC    = 8,
   parameter logic [NUM_SRC-1:0]   LEVEL_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] flag_w1c,
   input  logic [NUM_SRC-1:0] svc_oh,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] pend
);
   // level lines do not consume the clear strobes
   logic unused_lvl;
   assign unused_lvl = &{1'b0, flag_w1c & LEVEL_MASK, svc_oh & LEVEL_MASK};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (LEVEL_MASK[i]) begin : g_lvl
         assign flag_q[i] = 1'b0;
         assign pend[i]   = src_req[i];
      end else begin : g_evt
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       f_q <= 1'b0;
            else if (src_req[i])              f_q <= 1'b1;   // new event wins
            else if (flag_w1c[i] || svc_oh[i]) f_q <= 1'b0;
         end
         assign flag_q[i] = f_q;
         assign pend[i]   = f_q;
      end
   end
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 4
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [NUM_SRC-1:0] oh
);
   // scan downward so the lowest set index is written last
   always_comb begin
      any = 1'b0;
      idx = '0;
      oh  = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) begin
            any   = 1'b1;
            idx   = IDX_W'(i);
            oh    = '0;
            oh[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ivu_seq.sv
module ivu_seq
   import ivu_pkg::*;
#(
   parameter int                NUM_SRC   = 8,
   parameter int                IDX_W     = 4,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
   parameter int                RESP_CYC  = 5,
   parameter int                WAKE_CYC  = 5,
   parameter int                RET_CYC   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               any,
   input  logic [IDX_W-1:0]   sel_idx,
   input  logic [NUM_SRC-1:0] sel_oh,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               ret_strobe,
   input  logic               insn_bound,
   input  logic               core_sleep,
   input  logic               boot_vec_sel,
   input  logic               take_ack,
   output logic               accept,
   output logic [NUM_SRC-1:0] svc_oh,
   output logic               take_req,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               gie
);
   localparam int CNT_MAX = RESP_CYC + WAKE_CYC + RET_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   ivu_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [IDX_W-1:0] idx_q;
   logic             gie_q, shadow_q;
   logic             ret_go, ret_fin;
   logic [ADDR_W-1:0] base;

   assign accept  = (st_q == IVU_IDLE) && gie_q && !shadow_q && !gie_clr &&
                    !ret_strobe && any && (insn_bound || core_sleep);
   assign ret_go  = (st_q == IVU_IDLE) && ret_strobe;
   assign ret_fin = (st_q == IVU_RET) && (cnt_q == '0);
   assign svc_oh  = accept ? sel_oh : '0;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      case (st_q)
         IVU_IDLE: begin
            if (accept) begin
               st_d  = IVU_RESP;
               cnt_d = core_sleep ? CNT_W'(RESP_CYC + WAKE_CYC - 1)
                                  : CNT_W'(RESP_CYC - 1);
            end else if (ret_go) begin
               st_d  = IVU_RET;
               cnt_d = CNT_W'(RET_CYC - 1);
            end
         end
         IVU_RESP: begin
            if (cnt_q == '0) st_d = IVU_TAKE;
            else             cnt_d = cnt_q - 1'b1;
         end
         IVU_TAKE: begin
            if (take_ack) st_d = IVU_IDLE;
         end
         IVU_RET: begin
            if (cnt_q == '0) st_d = IVU_IDLE;
            else             cnt_d = cnt_q - 1'b1;
         end
         default: st_d = IVU_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= IVU_IDLE;
         cnt_q    <= '0;
         idx_q    <= '0;
         gie_q    <= 1'b0;
         shadow_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         if (accept) idx_q <= sel_idx;
         if (gie_clr || accept)        gie_q <= 1'b0;
         else if (gie_set || ret_fin)  gie_q <= 1'b1;
         if (gie_set || ret_fin)       shadow_q <= 1'b1;
         else if (insn_bound)          shadow_q <= 1'b0;
      end
   end

   assign base     = boot_vec_sel ? BOOT_BASE : '0;
   assign vec_addr = base + ((ADDR_W'(idx_q) + ADDR_W'(1)) << 1);
   assign take_req = (st_q == IVU_TAKE);
   assign gie      = gie_q;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
   parameter int                   NUM_SRC    = 8,
   parameter logic [NUM_SRC-1:0]   LEVEL_MASK = 8'hC0,
   parameter int                   ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]    BOOT_BASE  = 16'h3800,
   parameter int                   RESP_CYC   = 5,
   parameter int                   WAKE_CYC   = 5,
   parameter int                   RET_CYC    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] flag_w1c,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               ret_strobe,
   input  logic               insn_bound,
   input  logic               core_sleep,
   input  logic               boot_vec_sel,
   input  logic               take_ack,
   output logic               take_req,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               gie,
   output logic [NUM_SRC-1:0] flag_q
);
   localparam int IDX_W = $clog2(NUM_SRC + 1);

   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_num
      $error("NUM_SRC out of range");
   end
   if (RESP_CYC < 1 || RET_CYC < 1 || WAKE_CYC < 0) begin : g_bad_cyc
      $error("cycle counts out of range");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for vector table");
   end

   logic [NUM_SRC-1:0] pend, armed, sel_oh, svc_oh;
   logic [IDX_W-1:0]   sel_idx;
   logic               any, accept;

   ivu_flag_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) flags_i (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .flag_w1c(flag_w1c),
      .svc_oh(svc_oh), .flag_q(flag_q), .pend(pend)
   );

   assign armed = pend & src_en;

   ivu_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) prio_i (
      .req(armed), .any(any), .idx(sel_idx), .oh(sel_oh)
   );

   ivu_seq #(
      .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE),
      .RESP_CYC(RESP_CYC), .WAKE_CYC(WAKE_CYC), .RET_CYC(RET_CYC)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .any(any), .sel_idx(sel_idx), .sel_oh(sel_oh),
      .gie_set(gie_set), .gie_clr(gie_clr), .ret_strobe(ret_strobe),
      .insn_bound(insn_bound), .core_sleep(core_sleep),
      .boot_vec_sel(boot_vec_sel), .take_ack(take_ack),
      .accept(accept), .svc_oh(svc_oh), .take_req(take_req),
      .vec_addr(vec_addr), .gie(gie)
   );
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
   parameter int                NUM_SRC   = 8,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
   parameter int                RESP_CYC  = 5,
   parameter int                WAKE_CYC  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               accept,
   input logic               core_sleep,
   input logic               take_req,
   input logic               take_ack,
   input logic               gie,
   input logic               gie_clr,
   input logic [NUM_SRC-1:0] flag_q,
   input logic [NUM_SRC-1:0] flag_w1c,
   input logic [NUM_SRC-1:0] svc_oh,
   input logic [ADDR_W-1:0]  vec_addr,
   input logic               boot_vec_sel
);
   localparam int LAT_W = $clog2(RESP_CYC + WAKE_CYC + 2) + 1;
   localparam logic [LAT_W-1:0] LAT_MAX = '1;

   logic [LAT_W-1:0]   lat_q;
   logic               slp_q;
   logic [NUM_SRC-1:0] keep;
   logic [ADDR_W-1:0]  offs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         slp_q <= 1'b0;
      end else if (accept) begin
         lat_q <= '0;
         slp_q <= core_sleep;
      end else if (lat_q != LAT_MAX) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   assign keep = flag_q & ~flag_w1c & ~svc_oh;
   assign offs = vec_addr - (boot_vec_sel ? BOOT_BASE : '0);

   // R7
   take_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_req && !take_ack) |=> take_req);

   // R7
   resp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(take_req) |-> (lat_q == (slp_q ? LAT_W'(RESP_CYC + WAKE_CYC)
                                           : LAT_W'(RESP_CYC))));

   // R11
   gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr |=> !gie);

   // R6
   entry_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !gie);

   // R2
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (keep != '0) |=> ((flag_q & $past(keep)) == $past(keep)));

   // R8
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |-> (offs[0] == 1'b0 && offs != '0 &&
                    offs <= ADDR_W'(2 * NUM_SRC)));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE),
   .RESP_CYC(RESP_CYC), .WAKE_CYC(WAKE_CYC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .accept(accept), .core_sleep(core_sleep),
   .take_req(take_req), .take_ack(take_ack), .gie(gie), .gie_clr(gie_clr),
   .flag_q(flag_q), .flag_w1c(flag_w1c), .svc_oh(svc_oh),
   .vec_addr(vec_addr), .boot_vec_sel(boot_vec_sel)
);

// File: tb/irq_vector_unit_tb_top.sv
`timescale 1ns/1ps
module irq_vector_unit_tb_top;
   localparam int         N    = 8;
   localparam logic [7:0] LVL  = 8'hC0;
   localparam logic [15:0] BOOT = 16'h3800;

   // {pattern, enable, boot_sel, expected index}
   localparam logic [19:0] VEC_TAB [6] = '{
      {8'h06, 8'hFF, 1'b0, 3'd1},
      {8'h28, 8'hFF, 1'b1, 3'd3},
      {8'h28, 8'h20, 1'b0, 3'd5},
      {8'h80, 8'hFF, 1'b0, 3'd7},
      {8'hC1, 8'h80, 1'b0, 3'd7},
      {8'h01, 8'hFF, 1'b1, 3'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] src_req = '0, src_en = '0, flag_w1c = '0;
   logic gie_set = 0, gie_clr = 0, ret_strobe = 0, insn_bound = 0;
   logic core_sleep = 0, boot_vec_sel = 0, take_ack = 0;
   logic take_req, gie;
   logic [15:0] vec_addr;
   logic [N-1:0] flag_q;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_vector_unit dut_i (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .flag_w1c(flag_w1c), .gie_set(gie_set), .gie_clr(gie_clr),
      .ret_strobe(ret_strobe), .insn_bound(insn_bound), .core_sleep(core_sleep),
      .boot_vec_sel(boot_vec_sel), .take_ack(take_ack), .take_req(take_req),
      .vec_addr(vec_addr), .gie(gie), .flag_q(flag_q)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_take(output int n);
      n = 0;
      while (!take_req && n < 40) begin
         step();
         n++;
      end
   endtask

   task automatic quiet(input int cyc, input string req);
      bit seen = 0;
      for (int k = 0; k < cyc; k++) begin
         step();
         if (take_req) seen = 1;
      end
      chk(!seen, req, "no take expected", seen, 0);
   endtask

   initial begin
      #500000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      step();
      step();
      // R1 reset state
      chk(take_req == 0, "R1", "take_req", take_req, 0);
      chk(gie == 0, "R1", "gie", gie, 0);
      chk(flag_q == 0, "R1", "flags", flag_q, 0);
      rst_n = 1'b1;
      step();

      // table walk: R5 R6 R7 R8 R10
      foreach (VEC_TAB[e]) begin
         logic [7:0] pat, en, expf;
         logic bsel;
         int idx;
         logic [15:0] expa;
         {pat, en, bsel} = VEC_TAB[e][19:3];
         idx  = int'(VEC_TAB[e][2:0]);
         expa = (bsel ? BOOT : 16'h0) + 16'((idx + 1) * 2);
         expf = pat & ~LVL & ~(8'h1 << idx);
         src_en = en; boot_vec_sel = bsel; src_req = pat;
         step();
         src_req = pat & LVL;
         gie_set = 1; step(); gie_set = 0;
         insn_bound = 1; step(); step(); insn_bound = 0;
         wait_take(n);
         chk(n == RESP_N, "R7", "latency", n, RESP_N);
         chk(vec_addr == expa, "R5_R8", "vec_addr", vec_addr, expa);
         chk(flag_q == expf, "R6", "flags after entry", flag_q, expf);
         chk(gie == 0, "R6", "gie after entry", gie, 0);
         take_ack = 1; step(); take_ack = 0;
         chk(take_req == 0, "R7", "take_req after ack", take_req, 0);
         src_req = 0; flag_w1c = '1; step(); flag_w1c = 0;
      end
      boot_vec_sel = 0;

      // R2 masked event latches and stays
      src_en = 0; src_req = 8'h04; step(); src_req = 0;
      quiet(3, "R2");
      chk(flag_q == 8'h04, "R2", "flag latched", flag_q, 8'h04);
      src_en = 8'hFF;
      quiet(3, "R2");
      chk(flag_q == 8'h04, "R2", "flag held gie off", flag_q, 8'h04);
      // R3 write-one-to-clear
      flag_w1c = 8'h10; step(); flag_w1c = 0; step();
      chk(flag_q == 8'h04, "R3", "other flag kept", flag_q, 8'h04);
      flag_w1c = 8'h04; step(); flag_w1c = 0; step();
      chk(flag_q == 8'h00, "R3", "flag cleared", flag_q, 8'h00);

      // R4 level line gone before enable
      src_en = 0; src_req = 8'h40; step(); step(); src_req = 0; step();
      src_en = 8'hFF;
      gie_set = 1; step(); gie_set = 0;
      insn_bound = 1; step(); step(); insn_bound = 0;
      quiet(12, "R4");
      chk(flag_q == 0, "R4", "no level flag", flag_q, 0);

      // R11 clear in the acceptance cycle
      src_req = 8'h02; step(); src_req = 0;
      insn_bound = 1; gie_clr = 1; step(); insn_bound = 0; gie_clr = 0;
      quiet(12, "R11");
      chk(gie == 0, "R11", "gie", gie, 0);
      chk(flag_q == 8'h02, "R11", "flag still pending", flag_q, 8'h02);

      // R12 no boundary no acceptance, then sleep wake (R7)
      gie_set = 1; step(); gie_set = 0;
      insn_bound = 1; step(); insn_bound = 0;
      quiet(8, "R12");
      core_sleep = 1; step(); core_sleep = 0;
      wait_take(n);
      chk(n == RESP_N + WAKE_N, "R7", "sleep latency", n, RESP_N + WAKE_N);
      chk(vec_addr == 16'h0004, "R8", "vec_addr", vec_addr, 16'h0004);
      src_req = 8'h08; step(); src_req = 0; step(); step();
      chk(take_req == 1, "R7", "held without ack", take_req, 1);
      take_ack = 1; step(); take_ack = 0;

      // R9 return timing
      ret_strobe = 1; step(); ret_strobe = 0;
      chk(gie == 0, "R9", "gie right after return start", gie, 0);
      n = 0;
      while (!gie && n < 20) begin step(); n++; end
      chk(n == 5, "R9", "return length", n, 5);
      // R10 shadow after return
      insn_bound = 1; step(); insn_bound = 0;
      quiet(8, "R10");
      insn_bound = 1; step(); insn_bound = 0;
      wait_take(n);
      chk(n == RESP_N, "R10", "take after one instruction", n, RESP_N);
      chk(vec_addr == 16'h0008, "R10", "vec_addr", vec_addr, 16'h0008);
      take_ack = 1; step(); take_ack = 0;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   localparam int RESP_N = 5;
   localparam int WAKE_N = 5;
endmodule